// File: doc/BRIEF.md
# Termination Calibration Override Sequencer

This block is a one-shot controller that sits on a transceiver channel's dynamic reconfiguration register port. It takes the port's address, write data, enable and write-enable as outputs and the read data and ready as inputs. After reset it runs a fixed sequence without being asked. First it reads the 5-bit resistor calibration code from the channel. Then it applies a pair of static band-gap override levels. Next it forces the 3-bit termination-calibration override field to all ones. Last it writes a 15-bit resistor override word that it derives from the code.

The override word is computed, not looked up. Call the 5-bit quantity (18 − code) mod 32 the offset. The word is that offset placed three times side by side. Both partial-field updates use read-modify-write, so every bit outside the target field keeps its value.

Each port access issues a one-cycle enable and then waits for ready. If ready does not arrive within the watchdog limit, the sequence stops with an error flag. A `start` pulse given once the block has finished or failed runs the whole sequence again. The captured code and the computed word are brought out for observation.

Top module: `termcal_ovrd_seq`

## Requirements
- R1: While reset is high, `cfg_en` is 0, `done` is 0, `err` is 0, `bg_ovrd_en_n` is 1 and `bg_ovrd_val` is 0. After reset is released, the sequence starts without a `start` pulse.
- R2: `cal_code` reports bits [12:8] of the data read from address 0x105.
- R3: `ovrd_word` equals the 5-bit value (18 − code) mod 32 repeated three times. Examples: code 0 gives 0x4A52, code 18 gives 0x0000, code 19 gives 0x7FFF and code 31 gives 0x4E73.
- R4: After the code has been read, `bg_ovrd_en_n` becomes 0 and `bg_ovrd_val` becomes 18. Both are already at these levels before the first port write.
- R5: The register at 0x06A is read and then written back with bits [15:13] set to 3'b111 and bits [12:0] unchanged.
- R6: The register at 0x069 is read and then written back with bits [14:0] equal to `ovrd_word` and bit 15 unchanged.
- R7: Port accesses occur in exactly this order: read 0x105, read 0x06A, write 0x06A, read 0x069, write 0x069. No other register is touched.
- R8: `cfg_en` is high for one cycle per access, and no new access starts before the previous one has received `cfg_rdy`.
- R9: `done` rises once the final write is acknowledged and stays high until a `start` pulse, which clears it and re-runs the full sequence.
- R10: If `cfg_rdy` does not arrive within TIMEOUT (1024) cycles of an enable, `err` goes high. `done` then stays 0 and no further access is issued. A later `start` clears `err` and retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that re-runs the sequence once the block has finished or failed |
| cfg_en | output | 1 | One-cycle access enable to the register port |
| cfg_we | output | 1 | Write enable qualifying `cfg_en` |
| cfg_addr | output | ADDR_W (10) | Register address |
| cfg_wdata | output | DATA_W (16) | Write data |
| cfg_rdata | input | DATA_W (16) | Read data, valid with `cfg_rdy` |
| cfg_rdy | input | 1 | Access completion strobe |
| bg_ovrd_en_n | output | 1 | Band-gap override enable, 0 once applied |
| bg_ovrd_val | output | 5 | Band-gap override level, 18 once applied |
| cal_code | output | 5 | Captured calibration code |
| ovrd_word | output | 15 | Computed resistor override word |
| done | output | 1 | Sequence finished, held |
| err | output | 1 | Port watchdog expired, held |

## Verification
Each access reaches the port one cycle after the controller decides on it. The access completes on the clock edge that samples `cfg_rdy`. Two cycles after that edge, the port shows the next enable. `done` goes high on the edge that follows the last ready.

The register stub answers after a random delay of zero to three cycles. For that reason the bench does not count a fixed number of cycles. It waits for `done` or `err` and samples on falling edges, then compares the stub's contents and its access log with values computed from the code. The timeout case waits well past 1024 cycles before checking `err`. The `done` clear is checked one edge after the `start` pulse.

// File: rtl/termcal_pkg.sv
package termcal_pkg;
  localparam int CODE_W   = 5;   // width of the calibration code
  localparam int CODE_LSB = 8;   // code position inside its register
  localparam int TERM_W   = 3;   // termination override field width
  localparam int TERM_LSB = 13;  // termination override field position
  localparam int WORD_REP = 3;   // copies of the offset in the word
  localparam int WORD_W   = CODE_W * WORD_REP;
  localparam int BG_W     = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CODE, S_BG, S_RD_TERM, S_WR_TERM,
    S_RD_RCAL, S_WR_RCAL, S_DONE, S_ERR
  } seq_state_t;
endpackage

// File: rtl/termcal_word_calc.sv
module termcal_word_calc #(
  parameter int CODE_W = 5,
  parameter int REPS   = 3,
  parameter int CENTER = 18
) (
  input  logic [CODE_W-1:0]      code,
  output logic [CODE_W*REPS-1:0] word
);
  localparam logic [CODE_W-1:0] CTR = CODE_W'(CENTER);

  logic [CODE_W-1:0] offs;
  // modulo 2^CODE_W wraps naturally in the subtraction
  assign offs = CTR - code;

  for (genvar g = 0; g < REPS; g++) begin : g_rep
    assign word[g*CODE_W +: CODE_W] = offs;
  end
endmodule

// File: rtl/termcal_port_engine.sv
module termcal_port_engine #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic              tmo,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cfg_en,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic              cfg_rdy
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             waiting;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting   <= 1'b0;
      cnt       <= '0;
      ack       <= 1'b0;
      tmo       <= 1'b0;
      rsp_data  <= '0;
      cfg_en    <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
    end else begin
      cfg_en <= 1'b0;
      ack    <= 1'b0;
      tmo    <= 1'b0;
      if (!waiting) begin
        if (req) begin
          cfg_en    <= 1'b1;
          cfg_we    <= req_we;
          cfg_addr  <= req_addr;
          cfg_wdata <= req_wdata;
          waiting   <= 1'b1;
          cnt       <= '0;
        end
      end else if (cfg_rdy) begin
        waiting  <= 1'b0;
        ack      <= 1'b1;
        rsp_data <= cfg_rdata;
      end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
        waiting <= 1'b0;
        tmo     <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: enable is a single-cycle strobe
  p_en_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> !cfg_en);
  // R8: controller never requests while an access is outstanding
  p_no_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !req);
  // R10: the wait counter stays below the limit
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (int'(cnt) < TIMEOUT));
  // R10: completion and timeout are exclusive
  p_ack_tmo_r10: assert property (@(posedge clk) disable iff (rst)
    !(ack && tmo));
endmodule

// File: rtl/termcal_ovrd_seq.sv
module termcal_ovrd_seq
  import termcal_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter int              DATA_W    = 16,
  parameter int              TIMEOUT   = 1024,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 10'h105,
  parameter logic [ADDR_W-1:0] TERM_ADDR = 10'h06A,
  parameter logic [ADDR_W-1:0] RCAL_ADDR = 10'h069,
  parameter int              BG_LEVEL  = 18,
  parameter int              CENTER    = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              cfg_en,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic              cfg_rdy,
  output logic              bg_ovrd_en_n,
  output logic [BG_W-1:0]   bg_ovrd_val,
  output logic [CODE_W-1:0] cal_code,
  output logic [WORD_W-1:0] ovrd_word,
  output logic              done,
  output logic              err
);
  localparam logic [DATA_W-1:0] TERM_MASK = DATA_W'({TERM_W{1'b1}}) << TERM_LSB;
  localparam logic [DATA_W-1:0] WORD_MASK = DATA_W'({WORD_W{1'b1}});

  seq_state_t        state;
  logic              boot;
  logic              req, req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              ack, tmo;
  logic [DATA_W-1:0] rsp_data;
  logic [WORD_W-1:0] calc_word;

  termcal_word_calc #(.CODE_W(CODE_W), .REPS(WORD_REP), .CENTER(CENTER)) calc_i (
    .code(cal_code), .word(calc_word)
  );

  termcal_port_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) eng_i (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .tmo(tmo), .rsp_data(rsp_data),
    .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rdy(cfg_rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      boot         <= 1'b1;
      req          <= 1'b0;
      req_we       <= 1'b0;
      req_addr     <= '0;
      req_wdata    <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
      bg_ovrd_en_n <= 1'b1;
      bg_ovrd_val  <= '0;
      cal_code     <= '0;
      ovrd_word    <= '0;
    end else begin
      req <= 1'b0;
      if (tmo) begin
        err   <= 1'b1;
        state <= S_ERR;
      end else begin
        case (state)
          S_IDLE, S_DONE, S_ERR: begin
            if (boot || start) begin
              boot     <= 1'b0;
              done     <= 1'b0;
              err      <= 1'b0;
              req      <= 1'b1;
              req_we   <= 1'b0;
              req_addr <= CODE_ADDR;
              state    <= S_RD_CODE;
            end
          end
          S_RD_CODE: if (ack) begin
            cal_code <= rsp_data[CODE_LSB +: CODE_W];
            state    <= S_BG;
          end
          S_BG: begin
            bg_ovrd_en_n <= 1'b0;
            bg_ovrd_val  <= BG_W'(BG_LEVEL);
            ovrd_word    <= calc_word;
            req          <= 1'b1;
            req_we       <= 1'b0;
            req_addr     <= TERM_ADDR;
            state        <= S_RD_TERM;
          end
          S_RD_TERM: if (ack) begin
            req       <= 1'b1;
            req_we    <= 1'b1;
            req_wdata <= rsp_data | TERM_MASK;
            state     <= S_WR_TERM;
          end
          S_WR_TERM: if (ack) begin
            req      <= 1'b1;
            req_we   <= 1'b0;
            req_addr <= RCAL_ADDR;
            state    <= S_RD_RCAL;
          end
          S_RD_RCAL: if (ack) begin
            req       <= 1'b1;
            req_we    <= 1'b1;
            req_wdata <= (rsp_data & ~WORD_MASK) | DATA_W'(ovrd_word);
            state     <= S_WR_RCAL;
          end
          S_WR_RCAL: if (ack) begin
            done  <= 1'b1;
            state <= S_DONE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R4: band-gap overrides are in place before any write leaves the port
  p_bg_first_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we) |-> (!bg_ovrd_en_n && bg_ovrd_val == BG_W'(BG_LEVEL)));
  // R5: every write to the termination register carries the forced field
  p_term_field_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we && cfg_addr == TERM_ADDR) |-> ((cfg_wdata & TERM_MASK) == TERM_MASK));
  // R9: done holds until a start pulse
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R10: failure and completion are exclusive
  p_done_err_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R10: after failure the port stays quiet until restarted
  p_quiet_err_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> !cfg_en);
endmodule

// File: tb/termcal_ovrd_seq_tb.sv
module termcal_ovrd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst, start;
  logic        cfg_en, cfg_we, cfg_rdy;
  logic [9:0]  cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        bg_ovrd_en_n, done, err;
  logic [4:0]  bg_ovrd_val, cal_code;
  logic [14:0] ovrd_word;

  always #2 clk = ~clk;  // 250 MHz

  termcal_ovrd_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rdy(cfg_rdy), .bg_ovrd_en_n(bg_ovrd_en_n), .bg_ovrd_val(bg_ovrd_val),
    .cal_code(cal_code), .ovrd_word(ovrd_word), .done(done), .err(err)
  );

  int total = 0;
  int bad   = 0;

  // register stub state and access log
  logic [15:0] r_code, r_term, r_rcal;
  logic [15:0] o_term, o_rcal;
  bit          noresp, pending, prev_en;
  bit          p_we;
  logic [9:0]  p_addr;
  logic [15:0] p_data;
  int          dly, viol, log_n;
  logic [9:0]  log_addr [8];
  bit          log_we [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_word(input int code);
    int v;
    v = (18 - code + 32) % 32;
    return 15'(v | (v << 5) | (v << 10));
  endfunction

  task automatic stub_loop();
    forever begin
      @(negedge clk);
      cfg_rdy = 1'b0;
      if (prev_en && cfg_en) viol++;
      if (pending && !noresp) begin
        if (dly == 0) begin
          if (p_we) begin
            case (p_addr)
              10'h105: r_code = p_data;
              10'h06A: r_term = p_data;
              10'h069: r_rcal = p_data;
              default: ;
            endcase
          end else begin
            case (p_addr)
              10'h105: cfg_rdata = r_code;
              10'h06A: cfg_rdata = r_term;
              10'h069: cfg_rdata = r_rcal;
              default: cfg_rdata = 16'h0;
            endcase
          end
          cfg_rdy = 1'b1;
          pending = 0;
        end else dly--;
      end
      if (cfg_en) begin
        if (pending && !noresp) viol++;
        pending = 1;
        p_we = cfg_we; p_addr = cfg_addr; p_data = cfg_wdata;
        dly = $urandom_range(0, 3);
        if (log_n < 8) begin
          log_addr[log_n] = cfg_addr;
          log_we[log_n] = cfg_we;
        end
        log_n++;
      end
      prev_en = cfg_en;
    end
  endtask

  task automatic load(input int code);
    r_code = 16'($urandom());
    r_code[12:8] = 5'(code);
    r_term = 16'($urandom());
    r_rcal = 16'($urandom());
    o_term = r_term;
    o_rcal = r_rcal;
    log_n = 0;
    viol = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R9 done cleared by start", int'(done), 0);
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  task automatic check_run(input int code);
    logic [14:0] w;
    w = exp_word(code);
    chk(done && !err, "R9 done after sequence", int'({done, err}), 2);
    chk(cal_code == 5'(code), "R2 captured code", int'(cal_code), code);
    chk(ovrd_word == w, "R3 override word", int'(ovrd_word), int'(w));
    chk(!bg_ovrd_en_n && bg_ovrd_val == 5'd18, "R4 band-gap overrides",
        int'({bg_ovrd_en_n, bg_ovrd_val}), 18);
    chk(r_term == {3'b111, o_term[12:0]}, "R5 termination field RMW",
        int'(r_term), int'({3'b111, o_term[12:0]}));
    chk(r_rcal == {o_rcal[15], w}, "R6 override word RMW",
        int'(r_rcal), int'({o_rcal[15], w}));
    chk(log_n == 5, "R7 access count", log_n, 5);
    if (log_n == 5) begin
      chk(log_addr[0] == 10'h105 && !log_we[0], "R7 step0 read code", int'(log_addr[0]), 'h105);
      chk(log_addr[1] == 10'h06A && !log_we[1], "R7 step1 read term", int'(log_addr[1]), 'h06A);
      chk(log_addr[2] == 10'h06A &&  log_we[2], "R7 step2 write term", int'(log_addr[2]), 'h06A);
      chk(log_addr[3] == 10'h069 && !log_we[3], "R7 step3 read rcal", int'(log_addr[3]), 'h069);
      chk(log_addr[4] == 10'h069 &&  log_we[4], "R7 step4 write rcal", int'(log_addr[4]), 'h069);
    end
    chk(viol == 0, "R8 single enable, no overlap", viol, 0);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
  endtask

  task automatic main();
    int codes [4] = '{0, 18, 19, 31};
    rst = 1'b1; start = 1'b0; noresp = 0;
    load(5);
    repeat (4) @(negedge clk);
    chk(!cfg_en && !done && !err, "R1 reset outputs", int'({cfg_en, done, err}), 0);
    chk(bg_ovrd_en_n && bg_ovrd_val == 0, "R1 band-gap idle",
        int'({bg_ovrd_en_n, bg_ovrd_val}), 'h20);
    rst = 1'b0;
    wait_end(300);  // R1: runs with no start pulse
    check_run(5);
    foreach (codes[i]) begin
      load(codes[i]);
      pulse_start();
      wait_end(300);
      check_run(codes[i]);
    end
    for (int i = 0; i < 8; i++) begin
      int c;
      c = $urandom_range(0, 31);
      load(c);
      pulse_start();
      wait_end(300);
      check_run(c);
    end
    // R10: stalled port
    noresp = 1;
    load(7);
    pulse_start();
    repeat (1100) @(negedge clk);
    chk(err == 1'b1, "R10 err on timeout", int'(err), 1);
    chk(done == 1'b0, "R10 done low after timeout", int'(done), 0);
    chk(log_n == 1, "R10 no access after timeout", log_n, 1);
    noresp = 0;
    pending = 0;
    load(7);
    pulse_start();
    chk(err == 1'b0, "R10 err cleared by start", int'(err), 0);
    wait_end(300);
    check_run(7);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    cfg_rdy = 1'b0; cfg_rdata = '0; pending = 0; prev_en = 0; dly = 0;
    fork
      stub_loop();
      main();
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule